// File: doc/BRIEF.md
# Switching Output Stage Fault Supervisor

This block is the digital supervisor for an output stage of two half-bridges. It takes fault flags that are already synchronised: overcurrent, undervoltage, overtemperature error and overtemperature warning. It also takes an active-low control reset, a two-bit protection-mode selector and the two PWM inputs. From these it produces an enable and a drive level for each half-bridge, plus two active-low status levels: a shutdown flag and a temperature flag. A disabled half-bridge is understood to be high impedance.

One protection latch serves both half-bridges. Every hard fault sets the latch and disables both half-bridges. How the stage recovers depends on the mode. In autorecovery mode, recovery is timed by rising edges of the half-bridge A PWM input. At half the configured count the latch clears, but the outputs stay off. At the full count the outputs switch again. In latched mode, the stage stays off until the controller pulses the control reset low and then high.

Top module: `pstage_guard`

## Requirements
- R1: When `flt_oc`, `flt_uv` or `flt_ote` is high, `hb_a_en` and `hb_b_en` are low in the same cycle. From the next clock edge on, the protection latch is set.
- R2: While `flt_otw` is high, `otw_n` is low. The warning alone does not change the enables.
- R3: `mode_sel` 2'b00 selects autorecovery. The codes 2'b01, 2'b10 and 2'b11 all behave as latched shutdown.
- R4: In autorecovery mode the latch clears (`sd_n` returns high) after AR_CYCLES/2 synchronised rising edges of `pwm_a`, counted from the last fault. The enables return only after AR_CYCLES edges, which is 512 by default. With no edges, the count holds.
- R5: In latched mode a set latch stays set while the control reset stays high, however many PWM edges arrive. A falling edge of `ctrl_rst_n` clears it. Switching resumes once `ctrl_rst_n` is high again.
- R6: While `ctrl_rst_n` is low, both enables are low and `sd_n` is high, whatever the protection state.
- R7: The status pair (`otw_n`, `sd_n`) reads 2'b00 for a latched overtemperature error, 2'b10 for a latched overcurrent or undervoltage error, 2'b01 for a warning alone, and 2'b11 when there is no error and no warning.
- R8: With no error, the control reset high and the PWM inputs not both high, both enables are high. `hb_a_drive` and `hb_b_drive` follow `pwm_a` and `pwm_b` two clock cycles later (1 = supply side, 0 = ground).
- R9: While both synchronised PWM levels are high, both enables are low.
- R10: A fault that arrives during an autorecovery count sets the latch again and restarts the count from zero.
- R11: After the system reset `rst_n`, the latch is clear, and `sd_n` and `otw_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| ctrl_rst_n | input | 1 | Control reset from the controller, active low |
| mode_sel | input | 2 | Protection-mode selector |
| flt_oc | input | 1 | Overcurrent flag |
| flt_uv | input | 1 | Gate-supply undervoltage flag |
| flt_ote | input | 1 | Overtemperature error flag |
| flt_otw | input | 1 | Overtemperature warning flag |
| pwm_a | input | 1 | PWM input, half-bridge A |
| pwm_b | input | 1 | PWM input, half-bridge B |
| hb_a_en | output | 1 | Half-bridge A enable (0 = high impedance) |
| hb_a_drive | output | 1 | Half-bridge A level when enabled |
| hb_b_en | output | 1 | Half-bridge B enable (0 = high impedance) |
| hb_b_drive | output | 1 | Half-bridge B level when enabled |
| sd_n | output | 1 | Shutdown status, active low |
| otw_n | output | 1 | Temperature status, active low |

## Verification
The assertions check the following on every cycle:
- The immediate disable on any fault, and the latch being set on the next edge.
- The forced-off state with a high shutdown flag while the control reset is low.
- The ban on enabling with both PWM levels high.
- That the temperature flag tracks the warning.
- That a latched-mode shutdown never clears while the control reset stays high.

Only the bench scenarios can show the edge-counted timing: the exact edge at which the latch clears (256) and the edge at which switching resumes (512), the restart on a repeated fault, and the hold of the count when PWM stops. The same goes for the status encodings of each fault kind and the recovery through a reset pulse.

// File: rtl/pstage_pkg.sv
package pstage_pkg;

    typedef enum logic [1:0] {
        PM_AUTO   = 2'b00,
        PM_LATCH  = 2'b01,
        PM_RSVD_A = 2'b10,
        PM_RSVD_B = 2'b11
    } pmode_e;

    function automatic logic is_auto(input logic [1:0] sel);
        return pmode_e'(sel) == PM_AUTO;
    endfunction

endpackage

// File: rtl/pstage_pwm_sync.sv
module pstage_pwm_sync #(
    parameter int CH     = 2,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] pwm_in,
    output logic [CH-1:0] pwm_lvl,
    output logic [CH-1:0] pwm_rise
);
    localparam int PW = STAGES + 1;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [PW-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[PW-2:0], pwm_in[c]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= pipe_d;
        end

        // level is the last synchroniser stage; one more flop gives the edge
        assign pwm_lvl[c]  = pipe_q[STAGES-1];
        assign pwm_rise[c] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end

endmodule

// File: rtl/pstage_prot_core.sv
module pstage_prot_core
    import pstage_pkg::*;
#(
    parameter int AR_CYCLES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_rst_n,
    input  logic [1:0] mode_sel,
    input  logic       hard_fault,
    input  logic       ote_fault,
    input  logic       edge_tick,
    output logic       err_latched,
    output logic       err_is_ote,
    output logic       ar_holding
);
    localparam int CW   = $clog2(AR_CYCLES + 1);
    localparam int HALF = AR_CYCLES / 2;

    typedef struct packed {
        logic          err;
        logic          ote;
        logic          hold;
        logic [CW-1:0] cnt;
        logic          rst_prev;
    } core_t;

    core_t st_d, st_q;
    logic  auto_m, rst_fall;

    always_comb begin
        auto_m   = is_auto(mode_sel);
        rst_fall = st_q.rst_prev & ~ctrl_rst_n;
        st_d     = st_q;
        st_d.rst_prev = ctrl_rst_n;

        if (rst_fall) begin
            st_d.err  = 1'b0;
            st_d.ote  = 1'b0;
            st_d.hold = 1'b0;
            st_d.cnt  = '0;
        end else if (auto_m && st_q.hold && edge_tick) begin
            if (st_q.cnt == CW'(AR_CYCLES - 1)) begin
                st_d.hold = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt == CW'(HALF - 1)) begin
                st_d.err = 1'b0;
                st_d.ote = 1'b0;
            end
        end

        if (!auto_m) begin
            st_d.hold = 1'b0;
            st_d.cnt  = '0;
        end

        // a fault wins over every clearing path and restarts the count
        if (hard_fault) begin
            st_d.err  = 1'b1;
            st_d.ote  = ote_fault | (st_q.err & st_q.ote);
            st_d.hold = auto_m;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_latched = st_q.err;
    assign err_is_ote  = st_q.ote;
    assign ar_holding  = st_q.hold;

endmodule

// File: rtl/pstage_status.sv
module pstage_status (
    input  logic ctrl_rst_n,
    input  logic err_latched,
    input  logic err_is_ote,
    input  logic warn,
    output logic sd_n,
    output logic otw_n
);
    always_comb begin
        sd_n  = ~(err_latched & ctrl_rst_n);
        otw_n = ~(warn | (err_latched & err_is_ote));
    end
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard #(
    parameter int AR_CYCLES  = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_rst_n,
    input  logic [1:0] mode_sel,
    input  logic       flt_oc,
    input  logic       flt_uv,
    input  logic       flt_ote,
    input  logic       flt_otw,
    input  logic       pwm_a,
    input  logic       pwm_b,
    output logic       hb_a_en,
    output logic       hb_a_drive,
    output logic       hb_b_en,
    output logic       hb_b_drive,
    output logic       sd_n,
    output logic       otw_n
);
    localparam int NCH = 2;

    logic [NCH-1:0] lvl, rise;
    logic           any_fault, err_q, ote_q, hold_q, run;

    assign any_fault = flt_oc | flt_uv | flt_ote;

    pstage_pwm_sync #(.CH(NCH), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_in   ({pwm_b, pwm_a}),
        .pwm_lvl  (lvl),
        .pwm_rise (rise)
    );

    pstage_prot_core #(.AR_CYCLES(AR_CYCLES)) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_rst_n  (ctrl_rst_n),
        .mode_sel    (mode_sel),
        .hard_fault  (any_fault),
        .ote_fault   (flt_ote),
        .edge_tick   (rise[0]),
        .err_latched (err_q),
        .err_is_ote  (ote_q),
        .ar_holding  (hold_q)
    );

    pstage_status i_stat (
        .ctrl_rst_n  (ctrl_rst_n),
        .err_latched (err_q),
        .err_is_ote  (ote_q),
        .warn        (flt_otw),
        .sd_n        (sd_n),
        .otw_n       (otw_n)
    );

    always_comb begin
        run        = ctrl_rst_n & ~err_q & ~hold_q & ~any_fault & ~(&lvl);
        hb_a_en    = run;
        hb_b_en    = run;
        hb_a_drive = lvl[0];
        hb_b_drive = lvl[1];
    end

endmodule

// File: rtl/pstage_guard_chk.sv
module pstage_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_rst_n,
    input logic [1:0] mode_sel,
    input logic       flt_oc,
    input logic       flt_uv,
    input logic       flt_ote,
    input logic       flt_otw,
    input logic       hb_a_en,
    input logic       hb_a_drive,
    input logic       hb_b_en,
    input logic       hb_b_drive,
    input logic       sd_n,
    input logic       otw_n
);
    a_r1_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_oc || flt_uv || flt_ote) |-> (!hb_a_en && !hb_b_en));

    a_r1_fault_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_oc || flt_uv || flt_ote) |=> (!sd_n || !ctrl_rst_n));

    a_r2_warn_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flt_otw |-> !otw_n);

    a_r5_latched_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!sd_n) && $past(mode_sel != 2'b00) && $past(ctrl_rst_n) && ctrl_rst_n)
        |-> !sd_n);

    a_r6_ctrl_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rst_n |-> (sd_n && !hb_a_en && !hb_b_en));

    a_r8_en_implies_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_a_en || hb_b_en) |-> sd_n);

    a_r9_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_a_drive && hb_b_drive) |-> (!hb_a_en && !hb_b_en));
endmodule

bind pstage_guard pstage_guard_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_rst_n (ctrl_rst_n),
    .mode_sel   (mode_sel),
    .flt_oc     (flt_oc),
    .flt_uv     (flt_uv),
    .flt_ote    (flt_ote),
    .flt_otw    (flt_otw),
    .hb_a_en    (hb_a_en),
    .hb_a_drive (hb_a_drive),
    .hb_b_en    (hb_b_en),
    .hb_b_drive (hb_b_drive),
    .sd_n       (sd_n),
    .otw_n      (otw_n)
);

// File: tb/test_pstage_guard.sv
module test_pstage_guard;
    localparam int N = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_rst_n = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic flt_oc = 0, flt_uv = 0, flt_ote = 0, flt_otw = 0;
    logic pwm_a = 0, pwm_b = 0;
    logic hb_a_en, hb_a_drive, hb_b_en, hb_b_drive, sd_n, otw_n;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pstage_guard i_pstage_guard (
        .clk(clk), .rst_n(rst_n), .ctrl_rst_n(ctrl_rst_n), .mode_sel(mode_sel),
        .flt_oc(flt_oc), .flt_uv(flt_uv), .flt_ote(flt_ote), .flt_otw(flt_otw),
        .pwm_a(pwm_a), .pwm_b(pwm_b),
        .hb_a_en(hb_a_en), .hb_a_drive(hb_a_drive),
        .hb_b_en(hb_b_en), .hb_b_drive(hb_b_drive),
        .sd_n(sd_n), .otw_n(otw_n)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // packs {en_a, en_b, otw_n, sd_n}
    function automatic logic [3:0] obs();
        return {hb_a_en, hb_b_en, otw_n, sd_n};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pwm_a = 1'b1; cyc(4);
            pwm_a = 1'b0; cyc(4);
        end
    endtask

    task automatic fault_pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: flt_oc = 1'b1;
            1: flt_uv = 1'b1;
            default: flt_ote = 1'b1;
        endcase
        #1 check("R1 immediate off", {hb_a_en, hb_b_en, 2'b00}, 4'b0000);
        @(negedge clk);
        flt_oc = 0; flt_uv = 0; flt_ote = 0;
        cyc(2);
    endtask

    task automatic ctrl_reset_pulse();
        ctrl_rst_n = 1'b0; cyc(2);
        #1 check("R6 reset low", obs(), 4'b0011);
        ctrl_rst_n = 1'b1; cyc(2);
    endtask

    task automatic t_reset();
        #1 check("R11 reset state", {2'b00, otw_n, sd_n}, 4'b0011);
    endtask

    task automatic t_normal();
        pwm_a = 1; pwm_b = 0; cyc(3);
        check("R8 drive a=1 b=0", {hb_a_en, hb_b_en, hb_a_drive, hb_b_drive}, 4'b1110);
        pwm_a = 0; pwm_b = 1; cyc(1);
        check("R8 two-cycle latency", {2'b00, hb_a_drive, hb_b_drive}, 4'b0010);
        cyc(2);
        check("R8 drive a=0 b=1", {hb_a_en, hb_b_en, hb_a_drive, hb_b_drive}, 4'b1101);
        pwm_a = 1; cyc(3);
        check("R9 both high off", {hb_a_en, hb_b_en, 2'b11}, 4'b0011);
        pwm_a = 0; pwm_b = 0; cyc(3);
        check("R9 released", obs(), 4'b1111);
    endtask

    task automatic t_warn();
        flt_otw = 1; cyc(1);
        check("R2 R7 warning only", obs(), 4'b1101);
        flt_otw = 0; cyc(1);
        check("R7 normal", obs(), 4'b1111);
    endtask

    task automatic t_latched(input logic [1:0] m, input int kind, input logic [3:0] st);
        mode_sel = m; cyc(2);
        fault_pulse(kind);
        check("R7 latched status", obs(), st);
        pulses(N + 8);
        check("R3 R5 no autorecovery", obs(), st);
        ctrl_reset_pulse();
        check("R5 resume after reset", obs(), 4'b1111);
    endtask

    task automatic t_auto();
        mode_sel = 2'b00; cyc(2);
        fault_pulse(1);
        check("R7 uv status", obs(), 4'b0010);
        pulses(N/2 - 1);
        check("R4 before half", obs(), 4'b0010);
        cyc(40);
        check("R4 count holds", obs(), 4'b0010);
        pulses(1);
        check("R4 latch cleared at half", obs(), 4'b0011);
        pulses(N/2 - 1);
        check("R4 still off before full", obs(), 4'b0011);
        pulses(1);
        check("R4 resume at full", obs(), 4'b1111);
    endtask

    task automatic t_restart();
        mode_sel = 2'b00; cyc(2);
        fault_pulse(0);
        pulses(300);
        check("R10 mid count", obs(), 4'b0011);
        fault_pulse(2);
        check("R10 relatched ote", obs(), 4'b0000);
        pulses(N/2 - 1);
        check("R10 restarted half", obs(), 4'b0000);
        pulses(1);
        check("R10 half after restart", obs(), 4'b0011);
        pulses(N/2 - 1);
        check("R10 before full", obs(), 4'b0011);
        pulses(1);
        check("R10 full after restart", obs(), 4'b1111);
    endtask

    task automatic t_reset_masks();
        mode_sel = 2'b01; cyc(2);
        fault_pulse(0);
        ctrl_rst_n = 0; cyc(1);
        check("R6 sd high during reset", obs(), 4'b0011);
        ctrl_rst_n = 1; cyc(2);
        check("R5 cleared by reset", obs(), 4'b1111);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_normal();
        t_warn();
        t_latched(2'b01, 0, 4'b0010);
        t_latched(2'b11, 2, 4'b0000);
        t_latched(2'b10, 1, 4'b0010);
        t_auto();
        t_restart();
        t_reset_masks();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule